// File: doc/BRIEF.md
# Four-Operand Carry-Chain Integer Unit

This block is the combinational execution stage for a class of integer operations that names four registers. It receives an 8-bit sub-opcode and the values of three source registers, called b, c and d. It produces at most two results, and each result has its own write-enable. The primary result always targets register a. The secondary result targets either register b or register d, and an output pin tells the register file which one.

The arithmetic sub-opcodes add or subtract b and c. There is no flags register. A carry or borrow is taken from a general register (d), written into d, or both. A carry written into d is a plain 0 or 1 across the full register width. The non-arithmetic sub-opcodes are a bitwise select by mask (b is the mask, c and d are the sources), the same select with the mask inverted, and a sort of c and d into a maximum and a minimum.

Sub-opcodes 0x0C to 0x0F are not executed by this unit. Sub-opcodes 0x14 to 0xFF are reserved. Every one of these raises an illegal-operation flag and suppresses all writes. The register width is a parameter.

Top module: `cc4_unit`

## Requirements
- R1: Sub-opcodes 0x00 (signed) and 0x03 (unsigned) set pri_data = b + c + d[0] modulo 2^W, with pri_we=1 and sec_we=0.
- R2: Sub-opcodes 0x01 (signed) and 0x04 (unsigned) set pri_data = b + c with no carry-in, and write a flag to d. The flag is two's-complement overflow for 0x01 and the carry out of the top bit for 0x04.
- R3: Sub-opcodes 0x02 (signed) and 0x05 (unsigned) set pri_data = b + c + d[0] and write to d the overflow (0x02) or top-bit carry (0x05) of that three-term sum.
- R4: Sub-opcodes 0x06 (signed) and 0x09 (unsigned) set pri_data = b - c - d[0] modulo 2^W, with sec_we=0.
- R5: Sub-opcodes 0x07 (signed) and 0x0A (unsigned) set pri_data = b - c and write a flag to d. The flag is two's-complement overflow for 0x07 and unsigned borrow (b < c) for 0x0A.
- R6: Sub-opcodes 0x08 (signed) and 0x0B (unsigned) set pri_data = b - c - d[0] and write to d the overflow (0x08) or unsigned borrow (0x0B) of that three-term difference.
- R7: Whenever a flag is written, sec_to_d=1 and sec_data is exactly 0 or 1 across all W bits.
- R8: Only bit 0 of d acts as the carry or borrow input. Bits W-1..1 of d have no effect on any output of an arithmetic sub-opcode.
- R9: Sub-opcode 0x10 gives pri_data = (c & ~b) | (d & b). Sub-opcode 0x11 gives pri_data = (c & b) | (d & ~b). Neither writes a secondary result.
- R10: Sub-opcodes 0x12 (signed compare) and 0x13 (unsigned compare) set pri_data to the larger of c and d and sec_data to the smaller, with sec_we=1 and sec_to_d=0 (target b).
- R11: Sub-opcodes 0x0C to 0x0F and 0x14 to 0xFF set illegal=1, pri_we=0 and sec_we=0.
- R12: Every other sub-opcode sets illegal=0 and pri_we=1. sec_we=1 only for the flag-writing and sort sub-opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sub_op | input | 8 | Sub-opcode selecting the operation |
| b_val | input | W | Value of register b (minuend or addend, select mask) |
| c_val | input | W | Value of register c |
| d_val | input | W | Value of register d (carry source, select source, sort operand) |
| pri_data | output | W | Result for register a |
| pri_we | output | 1 | Write-enable for register a |
| sec_data | output | W | Secondary result (flag or minimum) |
| sec_we | output | 1 | Write-enable for the secondary result |
| sec_to_d | output | 1 | 1: secondary result goes to d; 0: it goes to b |
| illegal | output | 1 | Sub-opcode not executed by this unit |

## Verification
The unit holds no state, so a decode fault shows at the ports in the same cycle the sub-opcode is applied. A wrong variant choice typically shows as a stray sec_we, a missing sec_we, or a primary result that is off by one from the unused carry. The bench compares every port against a reference built on 64-bit arithmetic, for each legal and many reserved sub-opcodes. Extreme operands sit at the signed and unsigned wrap points, where a swapped signed/unsigned flag or an inverted borrow differs from the reference. Upper bits of d are filled with noise so that a carry path reading more than bit 0 is caught on the first vector that uses it.

// File: rtl/cc4_pkg.sv
package cc4_pkg;

   typedef enum logic [2:0] {
      K_NONE,
      K_ARITH,
      K_SELECT,
      K_SELECT_INV,
      K_SORT
   } cc4_kind_e;

   typedef struct packed {
      cc4_kind_e kind;
      logic      is_sub;
      logic      use_in;
      logic      use_out;
      logic      is_signed;
   } cc4_ctrl_t;

   localparam logic [7:0] OP_ARITH_LAST = 8'h0B;
   localparam logic [7:0] OP_SUB_FIRST  = 8'h06;
   localparam logic [7:0] OP_SELECT     = 8'h10;
   localparam logic [7:0] OP_SELECT_INV = 8'h11;
   localparam logic [7:0] OP_SORT_S     = 8'h12;
   localparam logic [7:0] OP_SORT_U     = 8'h13;

endpackage

// File: rtl/cc4_decode.sv
module cc4_decode
   import cc4_pkg::*;
(
   input  logic [7:0] sub_op,
   output cc4_ctrl_t  ctl
);

   logic [3:0] variant;

   always_comb begin
      ctl.kind      = K_NONE;
      ctl.is_sub    = 1'b0;
      ctl.use_in    = 1'b0;
      ctl.use_out   = 1'b0;
      ctl.is_signed = 1'b0;
      variant       = 4'd0;
      if (sub_op <= OP_ARITH_LAST) begin
         ctl.kind   = K_ARITH;
         ctl.is_sub = (sub_op >= OP_SUB_FIRST);
         variant    = ctl.is_sub ? (sub_op[3:0] - 4'd6) : sub_op[3:0];
         ctl.is_signed = (variant < 4'd3);
         case (variant)
            4'd0, 4'd3: begin ctl.use_in = 1'b1; ctl.use_out = 1'b0; end
            4'd1, 4'd4: begin ctl.use_in = 1'b0; ctl.use_out = 1'b1; end
            default:    begin ctl.use_in = 1'b1; ctl.use_out = 1'b1; end
         endcase
      end else begin
         case (sub_op)
            OP_SELECT:     ctl.kind = K_SELECT;
            OP_SELECT_INV: ctl.kind = K_SELECT_INV;
            OP_SORT_S:     begin ctl.kind = K_SORT; ctl.is_signed = 1'b1; end
            OP_SORT_U:     ctl.kind = K_SORT;
            default:       ctl.kind = K_NONE;
         endcase
      end
   end

endmodule

// File: rtl/cc4_addsub.sv
module cc4_addsub #(
   parameter int W = 32
) (
   input  logic         sub,
   input  logic         carry_bit,
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] sum,
   output logic         carry_out,
   output logic         ovf
);

   localparam int LOW_W = W - 1;

   logic [W-1:0]   y_eff;
   logic           cin_eff;
   logic [LOW_W:0] low_part;
   logic [W:0]     full;

   always_comb begin
      y_eff    = sub ? ~y : y;
      cin_eff  = sub ? ~carry_bit : carry_bit;
      low_part = {1'b0, x[LOW_W-1:0]} + {1'b0, y_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin_eff};
      full     = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin_eff};
      sum       = full[W-1:0];
      carry_out = full[W];
      ovf       = low_part[LOW_W] ^ full[W];
   end

endmodule

// File: rtl/cc4_bitlogic.sv
module cc4_bitlogic #(
   parameter int W = 32
) (
   input  logic         invert,
   input  logic         sort_signed,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] c,
   input  logic [W-1:0] d,
   output logic [W-1:0] sel_y,
   output logic [W-1:0] max_y,
   output logic [W-1:0] min_y
);

   logic [W-1:0] eff_mask;
   logic         c_less;

   assign eff_mask = invert ? ~mask : mask;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sel_y[i] = eff_mask[i] ? d[i] : c[i];
   end

   always_comb begin
      c_less = sort_signed ? ($signed(c) < $signed(d)) : (c < d);
      max_y  = c_less ? d : c;
      min_y  = c_less ? c : d;
   end

   always_comb begin
      assert (((sel_y ^ c) & (sel_y ^ d)) == '0) else $error("AST_SEL_FROM_SOURCES"); // R9
      assert ((max_y == c && min_y == d) || (max_y == d && min_y == c)) else $error("AST_SORT_KEEPS_PAIR"); // R10
   end

endmodule

// File: rtl/cc4_unit.sv
module cc4_unit
   import cc4_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [7:0]   sub_op,
   input  logic [W-1:0] b_val,
   input  logic [W-1:0] c_val,
   input  logic [W-1:0] d_val,
   output logic [W-1:0] pri_data,
   output logic         pri_we,
   output logic [W-1:0] sec_data,
   output logic         sec_we,
   output logic         sec_to_d,
   output logic         illegal
);

   if (W < 2) begin : g_bad_width
      $error("cc4_unit: W must be at least 2");
   end

   cc4_ctrl_t    ctl;
   logic [W-1:0] as_sum;
   logic         as_cout;
   logic         as_ovf;
   logic         flag;
   logic [W-1:0] sel_y;
   logic [W-1:0] max_y;
   logic [W-1:0] min_y;

   cc4_decode u_dec (
      .sub_op (sub_op),
      .ctl    (ctl)
   );

   cc4_addsub #(.W(W)) u_as (
      .sub       (ctl.is_sub),
      .carry_bit (ctl.use_in & d_val[0]),
      .x         (b_val),
      .y         (c_val),
      .sum       (as_sum),
      .carry_out (as_cout),
      .ovf       (as_ovf)
   );

   cc4_bitlogic #(.W(W)) u_bl (
      .invert      (ctl.kind == K_SELECT_INV),
      .sort_signed (ctl.is_signed),
      .mask        (b_val),
      .c           (c_val),
      .d           (d_val),
      .sel_y       (sel_y),
      .max_y       (max_y),
      .min_y       (min_y)
   );

   assign flag = ctl.is_signed ? as_ovf : (ctl.is_sub ? ~as_cout : as_cout);

   always_comb begin
      pri_data = '0;
      pri_we   = 1'b0;
      sec_data = '0;
      sec_we   = 1'b0;
      sec_to_d = 1'b0;
      illegal  = 1'b0;
      case (ctl.kind)
         K_ARITH: begin
            pri_data = as_sum;
            pri_we   = 1'b1;
            sec_data = {{(W-1){1'b0}}, flag};
            sec_we   = ctl.use_out;
            sec_to_d = ctl.use_out;
         end
         K_SELECT, K_SELECT_INV: begin
            pri_data = sel_y;
            pri_we   = 1'b1;
         end
         K_SORT: begin
            pri_data = max_y;
            pri_we   = 1'b1;
            sec_data = min_y;
            sec_we   = 1'b1;
         end
         default: illegal = 1'b1;
      endcase
   end

   always_comb begin
      assert (!(illegal && (pri_we || sec_we))) else $error("AST_ILLEGAL_NO_WRITE"); // R11
      assert (!(sec_we && sec_to_d) || (sec_data[W-1:1] == '0)) else $error("AST_FLAG_ONE_BIT"); // R7
      assert (pri_we == !illegal) else $error("AST_LEGAL_WRITES"); // R12
      assert (!(sec_we && !sec_to_d) || (ctl.kind == K_SORT)) else $error("AST_SEC_TO_B_ONLY_SORT"); // R10
   end

endmodule

// File: tb/tb_cc4_unit.sv
module tb_cc4_unit;

   localparam int W = 32;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [7:0]   sub_op;
   logic [W-1:0] b_val, c_val, d_val;
   logic [W-1:0] pri_data, sec_data;
   logic         pri_we, sec_we, sec_to_d, illegal;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   cc4_unit #(.W(W)) dut (
      .sub_op   (sub_op),
      .b_val    (b_val),
      .c_val    (c_val),
      .d_val    (d_val),
      .pri_data (pri_data),
      .pri_we   (pri_we),
      .sec_data (sec_data),
      .sec_we   (sec_we),
      .sec_to_d (sec_to_d),
      .illegal  (illegal)
   );

   function automatic string req_name(input logic [7:0] op);
      case (op)
         8'h00, 8'h03: return "R1";
         8'h01, 8'h04: return "R2";
         8'h02, 8'h05: return "R3";
         8'h06, 8'h09: return "R4";
         8'h07, 8'h0A: return "R5";
         8'h08, 8'h0B: return "R6";
         8'h10, 8'h11: return "R9";
         8'h12, 8'h13: return "R10";
         default:      return "R11";
      endcase
   endfunction

   // Reference: {illegal, pri_we, sec_we, sec_to_d, pri[31:0], sec[31:0]}
   function automatic logic [67:0] model(input logic [7:0] op, input logic [31:0] b,
                                         input logic [31:0] c, input logic [31:0] d);
      longint sb, sc, r;
      longint ub, uc;
      logic   cin, flg;
      logic [31:0] p, s;
      sb  = longint'($signed(b));
      sc  = longint'($signed(c));
      ub  = longint'({32'd0, b});
      uc  = longint'({32'd0, c});
      cin = d[0];
      p = '0; s = '0; flg = 1'b0;
      if (op <= 8'h05) begin
         logic ci;
         ci = (op == 8'h01 || op == 8'h04) ? 1'b0 : cin;
         if (op <= 8'h02) begin
            r = sb + sc + longint'(ci);
            flg = (r > 64'sd2147483647) || (r < -64'sd2147483648);
         end else begin
            r = ub + uc + longint'(ci);
            flg = (r > 64'sd4294967295);
         end
         p = r[31:0];
         if (op == 8'h00 || op == 8'h03) return {4'b0100, p, 32'd0};
         return {4'b0111, p, 31'd0, flg};
      end
      if (op <= 8'h0B) begin
         logic bi;
         bi = (op == 8'h07 || op == 8'h0A) ? 1'b0 : cin;
         if (op <= 8'h08) begin
            r = sb - sc - longint'(bi);
            flg = (r > 64'sd2147483647) || (r < -64'sd2147483648);
         end else begin
            r = ub - uc - longint'(bi);
            flg = (r < 0);
         end
         p = r[31:0];
         if (op == 8'h06 || op == 8'h09) return {4'b0100, p, 32'd0};
         return {4'b0111, p, 31'd0, flg};
      end
      if (op == 8'h10) return {4'b0100, (c & ~b) | (d & b), 32'd0};
      if (op == 8'h11) return {4'b0100, (c & b) | (d & ~b), 32'd0};
      if (op == 8'h12 || op == 8'h13) begin
         logic lt;
         lt = (op == 8'h12) ? (sc < longint'($signed(d))) : (c < d);
         p = lt ? d : c;
         s = lt ? c : d;
         return {4'b0110, p, s};
      end
      return {4'b1000, 32'd0, 32'd0};
   endfunction

   task automatic apply(input logic [7:0] op, input logic [31:0] b,
                        input logic [31:0] c, input logic [31:0] d, input string tag);
      logic [67:0] exp_v, act_v;
      logic [67:0] cmp_mask;
      @(negedge clk);
      sub_op = op; b_val = b; c_val = c; d_val = d;
      @(posedge clk);
      #1;
      exp_v = model(op, b, c, d);
      act_v = {illegal, pri_we, sec_we, sec_to_d, pri_data, sec_data};
      // data fields only matter when their enable is set
      cmp_mask = {4'hF, {32{exp_v[66]}}, {32{exp_v[65]}}};
      total++;
      if ((act_v & cmp_mask) !== (exp_v & cmp_mask)) begin
         bad++;
         $display("FAIL %s op=%02h b=%08h c=%08h d=%08h actual=%017h expected=%017h",
                  tag, op, b, c, d, act_v & cmp_mask, exp_v & cmp_mask);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      sub_op = 8'h00; b_val = '0; c_val = '0; d_val = '0;
      seed_dummy = $urandom(32'h5EED_C4C4);
      repeat (2) @(posedge clk);

      // idle state with zero inputs (R1)
      apply(8'h00, 32'd0, 32'd0, 32'd0, "R1");
      // wrap points for add
      apply(8'h00, 32'hFFFF_FFFF, 32'd0, 32'd1, "R1");
      apply(8'h01, 32'h7FFF_FFFF, 32'd1, 32'd0, "R2");
      apply(8'h04, 32'hFFFF_FFFF, 32'd1, 32'd0, "R2");
      apply(8'h02, 32'h7FFF_FFFF, 32'd0, 32'd1, "R3");
      apply(8'h05, 32'hFFFF_FFFF, 32'd0, 32'd1, "R3");
      // wrap points for subtract
      apply(8'h06, 32'd0, 32'd0, 32'd1, "R4");
      apply(8'h07, 32'h8000_0000, 32'd1, 32'd0, "R5");
      apply(8'h0A, 32'd3, 32'd4, 32'd0, "R5");
      apply(8'h0A, 32'd4, 32'd4, 32'd0, "R5");
      apply(8'h08, 32'h8000_0000, 32'd0, 32'd1, "R6");
      apply(8'h0B, 32'd4, 32'd4, 32'd1, "R6");
      // flag values are full-width 0 or 1, target d
      apply(8'h04, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R7");
      // upper bits of d ignored
      apply(8'h00, 32'd10, 32'd20, 32'hFFFF_FFFE, "R8");
      apply(8'h09, 32'd10, 32'd20, 32'hA5A5_A5A4, "R8");
      apply(8'h0B, 32'd10, 32'd5, 32'h8000_0001, "R8");
      // select
      apply(8'h10, 32'hFF00_FF00, 32'h1234_5678, 32'h9ABC_DEF0, "R9");
      apply(8'h11, 32'hFF00_FF00, 32'h1234_5678, 32'h9ABC_DEF0, "R9");
      // sort, signed vs unsigned disagreement and ties
      apply(8'h12, 32'd0, 32'hFFFF_FFFF, 32'd1, "R10");
      apply(8'h13, 32'd0, 32'hFFFF_FFFF, 32'd1, "R10");
      apply(8'h12, 32'd0, 32'd7, 32'd7, "R10");
      // not executed here / reserved
      apply(8'h0C, 32'd1, 32'd2, 32'd3, "R11");
      apply(8'h0F, 32'd1, 32'd2, 32'd3, "R11");
      apply(8'h14, 32'd1, 32'd2, 32'd3, "R11");
      apply(8'hFF, 32'd1, 32'd2, 32'd3, "R11");
      // write enables across all legal ops
      for (int k = 0; k < 20; k++) begin
         if (k < 12 || k >= 16) apply(8'(k), 32'h55, 32'hAA, 32'h1, "R12");
      end

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         logic [7:0]  op;
         logic [31:0] rb, rc, rd;
         op = (n % 8 == 7) ? 8'($urandom) : 8'($urandom_range(0, 19));
         rb = $urandom; rc = $urandom; rd = $urandom;
         case ($urandom_range(0, 5))
            0: rb = 32'h7FFF_FFFF;
            1: rc = 32'h8000_0000;
            2: rb = rc;
            default: ;
         endcase
         apply(op, rb, rc, rd, req_name(op));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule